// File: doc/BRIEF.md
# Ethernet Receive Ring Writer

This block sits between a MAC-side receive byte stream and a circular receive buffer in system memory. It packs arriving bytes into 32-bit words and writes them through a single word-wide write port. It puts a 4-byte header in front of every stored frame. While the body is being copied, the header carries a busy length marker. Once the frame ends, the header is rewritten with the real status and length. Only then does the hardware write pointer move past the frame, so the host never walks into a partly written frame.

The host tracks its position through a read-pointer register that holds the true read offset minus 16. The block derives the free space from that register, drops frames that would not fit, and counts each dropped frame. An address filter looks at the first six bytes of every frame and stores only frames accepted by the enable mask. Sticky receive-OK, receive-error and overflow flags tell the host what happened. Each flag is cleared by writing a one to its bit.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `wr_ptr` is 0, `capr` is 0xFFF0, `buf_empty` is 1, all three flags are 0, `missed` is 0 and `mem_we` is 0.
- R2: A stored frame occupies a header dword at its start offset S, followed by the frame bytes from S+4 on, packed little-endian (byte k of the frame lands in lane (S+4+k) mod 4). The final header word is {length[15:0], status[15:0]}, and the length counts every received byte, including the 4 trailing CRC bytes.
- R3: On a frame's first byte, the header dword is written as 0xFFF0_0000, with the length half reading 0xFFF0. The final header is written in the same cycle that `wr_ptr` advances.
- R4: The status bits are: bit0 set when no error input was set; bits 1..5 copy `rx_err[0..4]` (alignment, CRC, long, runt, invalid symbol); bit13 is broadcast (destination all ones); bit14 is destination equal to `station_addr`; bit15 is multicast (first destination byte has bit0 set, and the destination is not broadcast). Bits 6..12 are 0. Frames shorter than 6 bytes set none of bits 13..15.
- R5: A frame is stored when any of these holds: `cfg_accept[0]` (accept all), `cfg_accept[1]` together with an own-address match, `cfg_accept[2]` together with multicast, or `cfg_accept[3]` together with broadcast. `station_addr[7:0]` is the first destination byte on the wire. A rejected frame leaves `wr_ptr` and all flags unchanged.
- R6: After a frame of length L is stored at offset S, `wr_ptr` becomes the value of S+4+L rounded up to a multiple of 4, taken modulo the buffer size. Every write address is dword aligned.
- R7: Offsets wrap modulo the buffer size. A header or body word past the end continues at offset 0.
- R8: `cfg_size` values 0, 1, 2 and 3 select buffer sizes of 8192, 16384, 32768 and 65536 bytes. The caller reserves 16 more bytes of slack, which the block never addresses.
- R9: The true read offset is (`capr`+16) modulo the buffer size. A `capr_we` pulse loads `capr_wdata`. `buf_empty` is 1 exactly when the true read offset equals `wr_ptr`.
- R10: The free space F is the buffer size when the buffer is empty, and otherwise (read offset − `wr_ptr`) modulo the size. A frame with 4 + roundup4(L) ≥ F is dropped: `wr_ptr` is unchanged, `flag_ovf` is set and `missed` increments by one.
- R11: `flag_rok` is set when an accepted frame with status bit0 set commits its header. `flag_rerr` is set when an accepted frame with any error bit commits.
- R12: A one in `flag_clr` clears a flag ([0] receive-OK, [1] receive-error, [2] overflow). A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | 2 | Buffer size select; held static between resets |
| cfg_accept | input | 4 | Acceptance enables: accept all, own address, multicast, broadcast |
| station_addr | input | 48 | Own MAC address, first wire byte in [7:0] |
| rx_valid | input | 1 | Byte strobe; must be low in the cycle after `rx_last` |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_err | input | 5 | Error flags of the frame, sampled with `rx_last` |
| capr_we | input | 1 | Host write strobe for the read-pointer register |
| capr_wdata | input | 16 | New read-pointer value (true offset minus 16) |
| capr | output | 16 | Read-pointer register |
| buf_empty | output | 1 | Host has consumed everything committed |
| wr_ptr | output | 16 | Committed hardware write offset |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Byte offset of the written dword |
| mem_wdata | output | 32 | Written dword, little-endian |
| flag_clr | input | 3 | Write-one-to-clear for the three flags |
| flag_rok | output | 1 | Receive-OK flag |
| flag_rerr | output | 1 | Receive-error flag |
| flag_ovf | output | 1 | Overflow flag |
| missed | output | MISS_W | Dropped-frame counter |

## Verification
A wrong write offset shows up immediately. The next header lands at a misplaced address, and `wr_ptr` disagrees with the running sum of rounded frame lengths one cycle after the frame's last byte. An error in the free-space arithmetic surfaces only when the ring is nearly full: a frame is dropped or stored against expectation, and `missed`, `flag_ovf` and `wr_ptr` diverge on that frame. Errors in the filter or the status word show up in the committed header and flags of the same frame, so random traffic with mixed destination kinds and partial host consumption exposes most internal faults within a few frames.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_size,
  input  logic [3:0]        cfg_accept,
  input  logic [47:0]       station_addr,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [4:0]        rx_err,
  input  logic              capr_we,
  input  logic [15:0]       capr_wdata,
  output logic [15:0]       capr,
  output logic              buf_empty,
  output logic [15:0]       wr_ptr,
  output logic              mem_we,
  output logic [15:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [2:0]        flag_clr,
  output logic              flag_rok,
  output logic              flag_rerr,
  output logic              flag_ovf,
  output logic [MISS_W-1:0] missed
);
  typedef enum logic [1:0] {S_IDLE, S_BODY, S_FINAL, S_DROP} st_t;
  st_t st;

  logic [15:0] mask, rdo, new_wr, len16, status;
  logic [16:0] size, free, cnt, cnt_cur, body_off;
  logic [31:0] acc, acc_cur, acc_new;
  logic [47:0] da;
  logic [4:0]  errq;
  logic [1:0]  lane;
  logic byte_go, word_done, body_fit, hdr_need, hdr_fit, ovf_now;
  logic addr_ok, is_bc, is_mc, is_pm, accept, rx_ok, set_rok, set_rerr;

  assign size     = 17'd8192 << cfg_size;
  assign mask     = 16'(size - 17'd1);
  assign rdo      = (capr + 16'd16) & mask;
  assign free     = (rdo == wr_ptr) ? size : {1'b0, (rdo - wr_ptr) & mask};
  assign buf_empty = (rdo == wr_ptr);

  assign byte_go  = rx_valid && (st == S_IDLE || st == S_BODY);
  assign cnt_cur  = (st == S_BODY) ? cnt : '0;
  assign acc_cur  = (st == S_BODY) ? acc : '0;
  assign lane     = cnt_cur[1:0];
  assign acc_new  = acc_cur | ({24'd0, rx_data} << {lane, 3'b000});
  assign word_done = byte_go && (lane == 2'd3 || rx_last);
  assign body_off = 17'd4 + {cnt_cur[16:2], 2'b00};
  assign body_fit = ({1'b0, body_off} + 18'd4) < {1'b0, free};
  assign hdr_need = byte_go && (st == S_IDLE) && !rx_last;
  assign hdr_fit  = free > 17'd4;
  assign ovf_now  = byte_go && ((hdr_need && !hdr_fit) || (word_done && !body_fit));

  assign addr_ok  = cnt >= 17'd6;
  assign is_bc    = addr_ok && (da == 48'hFFFF_FFFF_FFFF);
  assign is_mc    = addr_ok && da[0] && !is_bc;
  assign is_pm    = addr_ok && (da == station_addr);
  assign accept   = cfg_accept[0] || (cfg_accept[1] && is_pm) ||
                    (cfg_accept[2] && is_mc) || (cfg_accept[3] && is_bc);
  assign rx_ok    = (errq == 5'd0);
  assign status   = {is_mc, is_pm, is_bc, 7'd0, errq, rx_ok};
  assign len16    = cnt[15:0];
  assign new_wr   = (wr_ptr + 16'd7 + len16) & mask & 16'hFFFC;
  assign set_rok  = (st == S_FINAL) && accept && rx_ok;
  assign set_rerr = (st == S_FINAL) && accept && !rx_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      acc <= '0;
      da <= '0;
      errq <= '0;
      wr_ptr <= '0;
      capr <= 16'hFFF0;
      mem_we <= 1'b0;
      mem_addr <= '0;
      mem_wdata <= '0;
      flag_rok <= 1'b0;
      flag_rerr <= 1'b0;
      flag_ovf <= 1'b0;
      missed <= '0;
    end else begin
      mem_we <= 1'b0;
      if (capr_we) capr <= capr_wdata;
      flag_rok  <= (flag_rok  && !flag_clr[0]) || set_rok;
      flag_rerr <= (flag_rerr && !flag_clr[1]) || set_rerr;
      flag_ovf  <= (flag_ovf  && !flag_clr[2]) || ovf_now;
      if (ovf_now) missed <= missed + 1'b1;
      case (st)
        S_IDLE, S_BODY: begin
          if (ovf_now) begin
            st <= rx_last ? S_IDLE : S_DROP;
          end else if (byte_go) begin
            if (hdr_need) begin
              mem_we <= 1'b1;
              mem_addr <= wr_ptr;
              mem_wdata <= 32'hFFF0_0000;
            end
            if (word_done) begin
              mem_we <= 1'b1;
              mem_addr <= (wr_ptr + body_off[15:0]) & mask;
              mem_wdata <= acc_new;
              acc <= '0;
            end else begin
              acc <= acc_new;
            end
            for (int i = 0; i < 6; i++)
              if (cnt_cur == 17'(i)) da[8*i +: 8] <= rx_data;
            cnt <= cnt_cur + 17'd1;
            if (rx_last) begin
              errq <= rx_err;
              st <= S_FINAL;
            end else begin
              st <= S_BODY;
            end
          end
        end
        S_FINAL: begin
          if (accept) begin
            mem_we <= 1'b1;
            mem_addr <= wr_ptr;
            mem_wdata <= {len16, status};
            wr_ptr <= new_wr;
          end
          st <= S_IDLE;
        end
        default: begin
          if (rx_valid && rx_last) st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic [15:0]       mem_addr,
  input logic [15:0]       wr_ptr,
  input logic [15:0]       capr,
  input logic              capr_we,
  input logic [15:0]       capr_wdata,
  input logic              flag_rok,
  input logic              flag_ovf,
  input logic [MISS_W-1:0] missed
);
  // R6
  wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[1:0] == 2'b00);

  // R6
  ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr[1:0] == 2'b00);

  // R3
  commit_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr != $past(wr_ptr) |-> mem_we && mem_addr == $past(wr_ptr));

  // R9
  capr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capr_we |=> capr == $past(capr_wdata));

  // R10
  miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    missed != $past(missed) |-> flag_ovf);

  // R11
  rok_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_rok) |-> wr_ptr != $past(wr_ptr));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.MISS_W(MISS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .wr_ptr(wr_ptr), .capr(capr), .capr_we(capr_we), .capr_wdata(capr_wdata),
  .flag_rok(flag_rok), .flag_ovf(flag_ovf), .missed(missed)
);

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [1:0]  cfg_size;
  logic [3:0]  cfg_accept;
  logic [47:0] station_addr;
  logic        rx_valid, rx_last, capr_we;
  logic [7:0]  rx_data;
  logic [4:0]  rx_err;
  logic [15:0] capr_wdata, capr, wr_ptr, mem_addr, missed;
  logic        buf_empty, mem_we, flag_rok, flag_rerr, flag_ovf;
  logic [31:0] mem_wdata;
  logic [2:0]  flag_clr;

  rx_ring_writer #(.MISS_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_accept(cfg_accept),
    .station_addr(station_addr), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err), .capr_we(capr_we),
    .capr_wdata(capr_wdata), .capr(capr), .buf_empty(buf_empty),
    .wr_ptr(wr_ptr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .flag_clr(flag_clr), .flag_rok(flag_rok),
    .flag_rerr(flag_rerr), .flag_ovf(flag_ovf), .missed(missed)
  );

  logic [31:0] bmem [2048];
  always @(posedge clk) if (mem_we) bmem[mem_addr[12:2]] <= mem_wdata;

  int nchk = 0, nerr = 0;
  int m_wr, m_capr, m_size, m_missed;
  bit m_rok, m_rerr, m_ovf;
  logic [7:0] fb [10000];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int rup4(input int v);
    return (v + 3) & ~3;
  endfunction

  function automatic logic [15:0] exp_status(input int len, input logic [4:0] e);
    logic [47:0] d;
    bit bc, mc, pm;
    for (int i = 0; i < 6; i++) d[8*i +: 8] = fb[i];
    bc = (len >= 6) && (d == {48{1'b1}});
    mc = (len >= 6) && d[0] && !bc;
    pm = (len >= 6) && (d == station_addr);
    return {mc, pm, bc, 7'd0, e, (e == 5'd0)};
  endfunction

  function automatic bit exp_accept(input logic [15:0] s);
    return cfg_accept[0] || (cfg_accept[1] && s[14]) ||
           (cfg_accept[2] && s[15]) || (cfg_accept[3] && s[13]);
  endfunction

  task automatic do_reset(input logic [1:0] sz);
    cfg_size = sz;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_wr = 0; m_capr = 16'hFFF0; m_size = 8192 << sz; m_missed = 0;
    m_rok = 0; m_rerr = 0; m_ovf = 0;
    @(negedge clk);
  endtask

  task automatic set_capr(input int v);
    capr_we = 1'b1; capr_wdata = 16'(v);
    @(negedge clk);
    capr_we = 1'b0;
    m_capr = v & 16'hFFFF;
  endtask

  task automatic fill_dest(input int kind);
    case (kind)
      0: for (int i = 0; i < 6; i++) fb[i] = 8'hFF;
      1: for (int i = 0; i < 6; i++) fb[i] = station_addr[8*i +: 8];
      2: begin
        for (int i = 0; i < 6; i++) fb[i] = 8'($urandom);
        fb[0][0] = 1'b1; fb[5] = 8'h01;
      end
      default: begin
        for (int i = 0; i < 6; i++) fb[i] = 8'($urandom);
        fb[0][0] = 1'b0; fb[0][1] = 1'b1;
      end
    endcase
  endtask

  task automatic run_frame(input int len, input logic [4:0] e, input bit gaps, input bit busy_chk);
    int rdo, fre, hdr, a;
    bit fit, acc;
    logic [15:0] st;
    rdo = (m_capr + 16) & (m_size - 1);
    fre = (rdo == m_wr) ? m_size : ((rdo - m_wr) & (m_size - 1));
    fit = (4 + rup4(len)) < fre;
    st = exp_status(len, e);
    acc = exp_accept(st);
    hdr = m_wr;
    for (int i = 0; i < len; i++) begin
      if (gaps && i > 0 && ($urandom % 4) == 0) begin
        rx_valid = 1'b0;
        @(negedge clk);
      end
      if (busy_chk && i == 8 && fit && m_size == 8192) begin
        check("R3 busy marker", {16'd0, bmem[hdr >> 2][31:16]}, 32'h0000_FFF0);
        check("R3 ptr held mid-frame", {16'd0, wr_ptr}, 32'(m_wr));
      end
      rx_valid = 1'b1; rx_data = fb[i]; rx_last = (i == len - 1);
      rx_err = (i == len - 1) ? e : 5'd0;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 5'd0;
    repeat (3) @(negedge clk);
    if (!fit) begin
      m_ovf = 1; m_missed++;
    end else if (acc) begin
      m_wr = (m_wr + 4 + rup4(len)) & (m_size - 1);
      if (st[0]) m_rok = 1; else m_rerr = 1;
      if (m_size == 8192) begin
        check("R2/R4 header", bmem[hdr >> 2], {16'(len), st});
        for (int i = 0; i < len; i++) begin
          a = (hdr + 4 + i) & (m_size - 1);
          if (bmem[a >> 2][8*(a%4) +: 8] !== fb[i])
            check("R2/R7 payload byte", {24'd0, bmem[a >> 2][8*(a%4) +: 8]}, {24'd0, fb[i]});
        end
        nchk++;
      end
    end
    check("R6 wr_ptr", {16'd0, wr_ptr}, 32'(m_wr));
    check("R11 rok/rerr flags", {30'd0, flag_rok, flag_rerr}, {30'd0, m_rok, m_rerr});
    check("R10 ovf/missed", {15'd0, flag_ovf, missed}, {15'd0, m_ovf, 16'(m_missed)});
    check("R9 buf_empty", {31'd0, buf_empty}, {31'd0, ((m_capr + 16) & (m_size - 1)) == m_wr});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    station_addr = 48'h5544_3322_1100;
    cfg_accept = 4'b1010;
    rx_valid = 0; rx_last = 0; rx_data = 0; rx_err = 0;
    capr_we = 0; capr_wdata = 0; flag_clr = 0;
    do_reset(2'd0);

    // R1 reset state
    check("R1 wr_ptr", {16'd0, wr_ptr}, 32'd0);
    check("R1 capr", {16'd0, capr}, 32'h0000_FFF0);
    check("R1 empty/flags/we", {27'd0, buf_empty, flag_rok, flag_rerr, flag_ovf, mem_we}, 32'h10);
    check("R1 missed", {16'd0, missed}, 32'd0);

    // R2 R3 R4 broadcast frame, busy marker
    fill_dest(0); for (int i = 6; i < 64; i++) fb[i] = 8'(i * 7);
    run_frame(64, 5'd0, 1'b0, 1'b1);
    // R6 odd length own-address frame
    fill_dest(1); for (int i = 6; i < 61; i++) fb[i] = 8'(i + 3);
    run_frame(61, 5'd0, 1'b1, 1'b1);
    // R5 multicast rejected while multicast enable is off
    fill_dest(2); for (int i = 6; i < 40; i++) fb[i] = 8'(i);
    run_frame(40, 5'd0, 1'b0, 1'b0);
    // R5 unicast to other station rejected
    fill_dest(3);
    run_frame(30, 5'd0, 1'b0, 1'b0);
    // R4 R11 stored error frame with CRC error
    fill_dest(0);
    run_frame(50, 5'b00010, 1'b0, 1'b0);
    // R4 short frame, accept all
    cfg_accept = 4'b0001;
    fb[0] = 8'hFF;
    run_frame(1, 5'd0, 1'b0, 1'b0);
    // R12 clear flags
    flag_clr = 3'b111; @(negedge clk); flag_clr = 3'b000; @(negedge clk);
    m_rok = 0; m_rerr = 0; m_ovf = 0;
    check("R12 flags cleared", {29'd0, flag_rok, flag_rerr, flag_ovf}, 32'd0);
    // R9 host consumes everything
    set_capr(m_wr - 16);
    check("R9 empty after consume", {31'd0, buf_empty}, 32'd1);
    check("R9 capr loaded", {16'd0, capr}, 32'((m_wr - 16) & 16'hFFFF));

    // R7 R10 random traffic with wrap and overflow
    for (int n = 0; n < 80; n++) begin
      cfg_accept = 4'($urandom);
      fill_dest($urandom % 4);
      begin
        int len;
        len = 1 + ($urandom % 500);
        for (int i = 6; i < len; i++) fb[i] = 8'($urandom);
        run_frame(len, (($urandom % 3) == 0) ? 5'($urandom) : 5'd0, 1'b1, 1'b0);
      end
      if (($urandom % 3) == 0) set_capr(m_wr - 16);
    end

    // R8 size select: 9000-byte frame fits 16K, overflows 8K
    do_reset(2'd1);
    cfg_accept = 4'b0001;
    for (int i = 0; i < 9000; i++) fb[i] = 8'(i);
    run_frame(9000, 5'd0, 1'b0, 1'b0);
    check("R8 16K commit", {16'd0, wr_ptr}, 32'd9004);
    do_reset(2'd0);
    run_frame(9000, 5'd0, 1'b0, 1'b0);
    check("R8 R10 8K drop", {16'd0, missed}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule